// File: doc/BRIEF.md
# Indirect Pointer Resolve Stage with Post-Increment

This pipeline stage sits between decode and execute and turns a memory-indirect operand into a final 15-bit address. Each incoming instruction token carries a 15-bit pointer location, a 3-bit data field, a generation tag and two flags: one marks the operand as indirect and the other asks for a post-increment of the pointer word. A token without the indirect flag is registered once and goes straight to the output with its address unchanged.

For an indirect token the stage reads the 12-bit pointer word through a combinational data-cache lookup. On a miss it requests a line fill and waits. On a hit with post-increment it forms (word + 1) mod 4096. It then sends a single-word masked write-through store to memory and, in the same cycle, broadcasts the new word to both the data cache and the instruction cache. The final address is the data field placed above the 12-bit word, and the token then waits at the output until execute takes it.

The stage also keeps its own generation value. A token whose tag matches neither that value nor the current global generation makes the stage adopt the global generation.

States: `ST_EMPTY` (no token held, input ready), `ST_RESOLVE` (indirect token held, looking up and possibly storing), `ST_SEND` (result held at the output). Transitions: EMPTY→SEND on accepting a direct token; EMPTY→RESOLVE on accepting an indirect token; RESOLVE→RESOLVE on a miss or on a blocked store; RESOLVE→SEND on a hit with no store needed, or on a hit whose store is accepted; SEND→SEND while the output is stalled, or on handing off while accepting a direct token; SEND→RESOLVE on handing off while accepting an indirect token; SEND→EMPTY on handing off with no new token.

Top module: `ind_resolve_stage`

## Requirements
- R1: While reset is asserted and right after it, `in_ready`=1 and `out_valid`, `fill_valid` and `st_valid` are 0, and `epoch` is 0.
- R2: A token with `in_ind`=0 raises `out_valid` in the cycle after it is accepted, with `out_addr` equal to `in_addr` and `out_gen` equal to `in_gen`. Its `in_inc` flag has no effect: no store and no cache update occur.
- R3: An indirect token without increment that hits in the cache produces `out_addr` = {data field, cached word}.
- R4: While an indirect token misses, `fill_valid` is 1 with `fill_line` = pointer address >> 3 (8 words per line), and `out_valid` stays 0. Once the line is present, processing resumes.
- R5: With increment, the new word is (cached word + 1) mod 4096, so 0xFFF becomes 0x000.
- R6: While an increment store is offered and `st_ready` is 0, the stage holds the token: `out_valid` stays 0 and no cache update occurs.
- R7: The store carries `st_line` = pointer address >> 3, and a `st_mask` that is one-hot with bit (pointer address mod 8) set, with `st_data` equal to the new word.
- R8: `upd_valid` pulses in exactly the cycle in which the store is accepted, with `upd_addr` equal to the pointer address and `upd_data` equal to the new word. This update goes to both caches.
- R9: After an increment, `out_addr` = {data field, incremented word}.
- R10: When a token is accepted whose `in_gen` differs from both `epoch` and `cur_gen`, `epoch` takes the value of `cur_gen` on the next cycle. Otherwise `epoch` is unchanged.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_addr` hold steady.
- R12: While a token is held in RESOLVE, or in SEND with `out_ready`=0, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_gen | input | 4 | Current global generation |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Stage accepts a token |
| in_ind | input | 1 | Operand is indirect |
| in_inc | input | 1 | Post-increment the pointer word |
| in_addr | input | 15 | Pointer location (or direct address) |
| in_df | input | 3 | Data field used for the final address |
| in_gen | input | 4 | Token generation tag |
| dc_addr | output | 15 | Data-cache lookup address |
| dc_hit | input | 1 | Lookup hit |
| dc_data | input | 12 | Word at the lookup address |
| fill_valid | output | 1 | Line fill request |
| fill_ready | input | 1 | Fill port can accept |
| fill_line | output | 12 | Line address to fill |
| st_valid | output | 1 | Write-through store offered |
| st_ready | input | 1 | Store port can accept |
| st_line | output | 12 | Store line address |
| st_mask | output | 8 | One-hot word mask within the line |
| st_data | output | 12 | Stored word |
| upd_valid | output | 1 | Update to data and instruction caches |
| upd_addr | output | 15 | Updated word address |
| upd_data | output | 12 | Updated word value |
| out_valid | output | 1 | Resolved token available |
| out_ready | input | 1 | Execute accepts the token |
| out_addr | output | 15 | Final address |
| out_gen | output | 4 | Token generation tag |
| epoch | output | 4 | Stage's adopted generation |

## Verification
A direct token shows up at the output one clock after the edge that accepts it. An indirect hit without increment takes two clocks: one edge for acceptance and one for resolution. An increment token also takes two clocks, provided the store port is ready. The fill request and the store offer are visible combinationally in the first cycle after acceptance. The `epoch` change appears one edge after acceptance. The driver pushes each expected result when it offers the token, and the monitor compares at falling edges against every output handshake and store handshake. The directed stall checks for misses, blocked stores and a blocked output are sampled at falling edges while the blocking input is held, a whole cycle after the edge that entered the stall.

// File: rtl/ind_resolve_pkg.sv
package ind_resolve_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_SEND    = 2'd2
    } ind_state_e;
endpackage

// File: rtl/ind_resolve_ctrl.sv
module ind_resolve_ctrl
    import ind_resolve_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_ind,
    input  logic hold_inc,
    input  logic dc_hit,
    input  logic st_ready,
    input  logic out_ready,
    output logic in_ready,
    output logic fill_req,
    output logic st_req,
    output logic resolve_done,
    output logic out_valid
);
    ind_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        in_ready     = 1'b0;
        fill_req     = 1'b0;
        st_req       = 1'b0;
        resolve_done = 1'b0;
        out_valid    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = in_ind ? ST_RESOLVE : ST_SEND;
            end
            ST_RESOLVE: begin
                if (!dc_hit) begin
                    fill_req = 1'b1;
                end else if (hold_inc) begin
                    st_req = 1'b1;
                    if (st_ready) begin
                        resolve_done = 1'b1;
                        state_d      = ST_SEND;
                    end
                end else begin
                    resolve_done = 1'b1;
                    state_d      = ST_SEND;
                end
            end
            ST_SEND: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    in_ready = 1'b1;
                    if (in_valid) state_d = in_ind ? ST_RESOLVE : ST_SEND;
                    else          state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end
endmodule

// File: rtl/ind_store_fmt.sv
module ind_store_fmt #(
    parameter int ADDR_W    = 15,
    parameter int WORD_W    = 12,
    parameter int LINE_LOG2 = 3,
    localparam int LINE_WORDS = 1 << LINE_LOG2,
    localparam int LINE_W     = ADDR_W - LINE_LOG2
) (
    input  logic [ADDR_W-1:0]     ptr_addr,
    input  logic [WORD_W-1:0]     word_in,
    input  logic                  do_inc,
    output logic [WORD_W-1:0]     word_out,
    output logic [LINE_W-1:0]     line,
    output logic [LINE_WORDS-1:0] mask
);
    logic [LINE_LOG2-1:0] offset;

    assign offset   = ptr_addr[LINE_LOG2-1:0];
    assign line     = ptr_addr[ADDR_W-1:LINE_LOG2];
    assign word_out = do_inc ? word_in + WORD_W'(1) : word_in;

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_mask
        assign mask[g] = (offset == LINE_LOG2'(g));
    end
endmodule

// File: rtl/ind_resolve_stage.sv
module ind_resolve_stage #(
    parameter int WORD_W    = 12,
    parameter int FIELD_W   = 3,
    parameter int LINE_LOG2 = 3,
    parameter int GEN_W     = 4,
    localparam int ADDR_W     = WORD_W + FIELD_W,
    localparam int LINE_WORDS = 1 << LINE_LOG2,
    localparam int LINE_W     = ADDR_W - LINE_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GEN_W-1:0]      cur_gen,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_ind,
    input  logic                  in_inc,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [FIELD_W-1:0]    in_df,
    input  logic [GEN_W-1:0]      in_gen,
    output logic [ADDR_W-1:0]     dc_addr,
    input  logic                  dc_hit,
    input  logic [WORD_W-1:0]     dc_data,
    output logic                  fill_valid,
    input  logic                  fill_ready,
    output logic [LINE_W-1:0]     fill_line,
    output logic                  st_valid,
    input  logic                  st_ready,
    output logic [LINE_W-1:0]     st_line,
    output logic [LINE_WORDS-1:0] st_mask,
    output logic [WORD_W-1:0]     st_data,
    output logic                  upd_valid,
    output logic [ADDR_W-1:0]     upd_addr,
    output logic [WORD_W-1:0]     upd_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [GEN_W-1:0]      out_gen,
    output logic [GEN_W-1:0]      epoch
);
    logic                 accept, resolve_done, fill_req, st_req;
    logic                 hold_inc;
    logic [ADDR_W-1:0]    hold_addr, res_addr;
    logic [FIELD_W-1:0]   hold_df;
    logic [GEN_W-1:0]     hold_gen, epoch_q;
    logic [WORD_W-1:0]    new_word;
    logic [LINE_W-1:0]    line_w;

    ind_resolve_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ind       (in_ind),
        .hold_inc     (hold_inc),
        .dc_hit       (dc_hit),
        .st_ready     (st_ready),
        .out_ready    (out_ready),
        .in_ready     (in_ready),
        .fill_req     (fill_req),
        .st_req       (st_req),
        .resolve_done (resolve_done),
        .out_valid    (out_valid)
    );

    ind_store_fmt #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .LINE_LOG2 (LINE_LOG2)
    ) u_fmt (
        .ptr_addr (hold_addr),
        .word_in  (dc_data),
        .do_inc   (hold_inc),
        .word_out (new_word),
        .line     (line_w),
        .mask     (st_mask)
    );

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_inc  <= 1'b0;
            hold_addr <= '0;
            hold_df   <= '0;
            hold_gen  <= '0;
            res_addr  <= '0;
            epoch_q   <= '0;
        end else begin
            if (accept) begin
                hold_inc  <= in_ind && in_inc;
                hold_addr <= in_addr;
                hold_df   <= in_df;
                hold_gen  <= in_gen;
                res_addr  <= in_addr;
                if (in_gen != epoch_q && in_gen != cur_gen) epoch_q <= cur_gen;
            end else if (resolve_done) begin
                res_addr <= {hold_df, new_word};
            end
        end
    end

    assign dc_addr    = hold_addr;
    assign fill_valid = fill_req;
    assign fill_line  = line_w;
    assign st_valid   = st_req;
    assign st_line    = line_w;
    assign st_data    = new_word;
    assign upd_valid  = st_req && st_ready;
    assign upd_addr   = hold_addr;
    assign upd_data   = new_word;
    assign out_addr   = res_addr;
    assign out_gen    = hold_gen;
    assign epoch      = epoch_q;

    a_r4_fill_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !dc_hit && !out_valid);
    a_r5_incremented_word: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_data == WORD_W'(dc_data + WORD_W'(1)));
    a_r6_store_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> !out_valid);
    a_r7_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $countones(st_mask) == 1);
    a_r8_update_with_store: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> st_valid && upd_data == st_data);
    a_r10_epoch_adopt: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_gen != epoch && in_gen != cur_gen |=> epoch == $past(cur_gen));
    a_r11_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr));
    a_r12_no_accept_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/sim_ind_resolve_stage.sv
`timescale 1ns/1ps
module sim_ind_resolve_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cur_gen = 4'd0;
    logic        in_valid = 1'b0, in_ind = 1'b0, in_inc = 1'b0;
    logic [14:0] in_addr = '0;
    logic [2:0]  in_df = '0;
    logic [3:0]  in_gen = '0;
    logic        in_ready;
    logic [14:0] dc_addr;
    logic        dc_hit;
    logic [11:0] dc_data;
    logic        fill_valid, fill_ready = 1'b1;
    logic [11:0] fill_line;
    logic        st_valid, st_ready = 1'b1;
    logic [11:0] st_line;
    logic [7:0]  st_mask;
    logic [11:0] st_data;
    logic        upd_valid;
    logic [14:0] upd_addr;
    logic [11:0] upd_data;
    logic        out_valid, out_ready = 1'b1;
    logic [14:0] out_addr;
    logic [3:0]  out_gen, epoch;

    int checks = 0;
    int errors = 0;

    logic [11:0] mem [64];
    logic [11:0] exp_mem [64];
    logic [7:0]  line_ok;
    logic [18:0] q_out [$];
    logic [46:0] q_st [$];

    always #4 clk = ~clk;

    ind_resolve_stage u0 (
        .clk(clk), .rst_n(rst_n), .cur_gen(cur_gen),
        .in_valid(in_valid), .in_ready(in_ready), .in_ind(in_ind), .in_inc(in_inc),
        .in_addr(in_addr), .in_df(in_df), .in_gen(in_gen),
        .dc_addr(dc_addr), .dc_hit(dc_hit), .dc_data(dc_data),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
        .st_mask(st_mask), .st_data(st_data),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_gen(out_gen), .epoch(epoch)
    );

    // Cache and memory model
    always_comb begin
        dc_hit  = line_ok[dc_addr[5:3]];
        dc_data = mem[dc_addr[5:0]];
    end

    always @(posedge clk) begin
        if (fill_valid && fill_ready) line_ok[fill_line[2:0]] <= 1'b1;
        if (upd_valid) mem[upd_addr[5:0]] <= upd_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [46:0] act, input logic [46:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares output and store handshakes against the queues
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q_out.size() == 0) chk(0, "R2/R3/R9 unexpected output", {28'd0, out_gen, out_addr}, '0);
            else begin
                logic [18:0] e;
                e = q_out.pop_front();
                chk({out_gen, out_addr} == e, "R2/R3/R9 output token", {28'd0, out_gen, out_addr}, {28'd0, e});
            end
        end
        if (rst_n && st_valid && st_ready) begin
            if (q_st.size() == 0) chk(0, "R2 unexpected store", {3'd0, st_line, st_mask, st_data, 12'd0}, '0);
            else begin
                logic [46:0] e;
                e = q_st.pop_front();
                chk({upd_addr, st_line, st_mask, st_data} == e, "R7 store line/mask/data",
                    {upd_addr, st_line, st_mask, st_data}, e);
                chk(upd_valid && upd_data == st_data, "R8 cache update with store",
                    {34'd0, upd_valid, upd_data}, {34'd0, 1'b1, st_data});
            end
        end
        if (rst_n && upd_valid && !(st_valid && st_ready))
            chk(0, "R6/R8 update without accepted store", 47'd1, 47'd0);
    end

    task automatic send(input bit ind, input bit inc, input logic [14:0] a,
                        input logic [2:0] df, input logic [3:0] g);
        logic [11:0] w;
        if (!ind) q_out.push_back({g, a});
        else begin
            w = exp_mem[a[5:0]];
            if (inc) begin
                w = w + 12'd1;
                exp_mem[a[5:0]] = w;
                q_st.push_back({a, a[14:3], 8'(1 << a[2:0]), w});
            end
            q_out.push_back({g, df, w});
        end
        @(negedge clk);
        in_valid = 1'b1; in_ind = ind; in_inc = inc; in_addr = a; in_df = df; in_gen = g;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        do begin @(negedge clk); n++; end
        while ((q_out.size() != 0 || q_st.size() != 0 || !in_ready || out_valid) && n < 200);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 12'((i * 37 + 5) & 12'hFFF);
        end
        mem[17] = 12'hFFF;
        for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
        line_ok = 8'b1101_1111; // line 5 absent

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready && !out_valid && !fill_valid && !st_valid && epoch == 0, "R1 reset outputs",
            {42'd0, in_ready, out_valid, fill_valid, st_valid, 1'b0}, {42'd0, 5'b10000});
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && epoch == 0, "R1 after reset",
            {45'd0, in_ready, out_valid}, {45'd0, 2'b10});

        // R2: direct token, increment flag ignored, due one cycle after acceptance
        send(0, 1, 15'h1234, 3'd5, 4'd0);
        @(negedge clk);
        chk(out_valid && out_addr == 15'h1234, "R2 direct passes in one cycle",
            {31'd0, out_valid, out_addr}, {31'd0, 1'b1, 15'h1234});
        drain();
        chk(mem[52] == exp_mem[52] && q_st.size() == 0, "R2 no store from direct token",
            {35'd0, mem[52]}, {35'd0, exp_mem[52]});

        // R3: indirect hit, no increment
        send(1, 0, 15'd3, 3'd2, 4'd0);
        drain();
        // R5/R9: ordinary increment and wrap from 0xFFF
        send(1, 1, 15'd10, 3'd1, 4'd0);
        send(1, 1, 15'd17, 3'd7, 4'd0);
        drain();
        chk(mem[17] == 12'h000, "R5 wrap to zero", {35'd0, mem[17]}, 47'd0);

        // R4: miss with fill port blocked
        fill_ready = 1'b0;
        send(1, 1, 15'd42, 3'd3, 4'd0);
        repeat (3) @(negedge clk);
        chk(fill_valid && fill_line == 12'd5 && !out_valid, "R4 fill requested while miss",
            {34'd0, fill_valid, fill_line}, {34'd0, 1'b1, 12'd5});
        chk(!in_ready, "R12 input blocked during resolve", {46'd0, in_ready}, 47'd0);
        fill_ready = 1'b1;
        drain();
        chk(line_ok[5] == 1'b1, "R4 resumes after fill", {46'd0, line_ok[5]}, 47'd1);

        // R6: store port blocked
        st_ready = 1'b0;
        send(1, 1, 15'd20, 3'd4, 4'd0);
        repeat (3) @(negedge clk);
        chk(st_valid && !out_valid && !upd_valid && mem[20] != exp_mem[20], "R6 stall on store port",
            {44'd0, st_valid, out_valid, upd_valid}, {44'd0, 3'b100});
        st_ready = 1'b1;
        drain();

        // R10: generation adoption
        cur_gen = 4'd5;
        send(0, 0, 15'd100, 3'd0, 4'd3);
        chk(epoch == 4'd5, "R10 adopt current generation", {43'd0, epoch}, 47'd5);
        drain();
        cur_gen = 4'd7;
        send(0, 0, 15'd101, 3'd0, 4'd5);
        chk(epoch == 4'd5, "R10 matching epoch keeps value", {43'd0, epoch}, 47'd5);
        drain();
        send(0, 0, 15'd102, 3'd0, 4'd7);
        chk(epoch == 4'd5, "R10 matching global keeps value", {43'd0, epoch}, 47'd5);
        drain();

        // R11/R12: output held while execute stalls
        out_ready = 1'b0;
        send(1, 0, 15'd33, 3'd6, 4'd7);
        repeat (4) @(negedge clk);
        chk(out_valid && out_addr == {3'd6, exp_mem[33]}, "R11 output held",
            {31'd0, out_valid, out_addr}, {31'd0, 1'b1, 3'd6, exp_mem[33]});
        chk(!in_ready, "R12 input blocked while output stalled", {46'd0, in_ready}, 47'd0);
        out_ready = 1'b1;
        drain();

        // Mixed back-to-back stream
        for (int k = 0; k < 12; k++) begin
            send(k % 3 != 0, k % 2 == 0, 15'((k * 11) % 64), 3'(k), 4'd7);
        end
        drain();
        chk(q_out.size() == 0 && q_st.size() == 0, "R9 stream drained",
            {15'd0, 32'(q_out.size())}, 47'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule